// File: doc/BRIEF.md
# Quadrature IQ Modulator Datapath

The block turns a pair of signed 8-bit baseband values (in-phase and quadrature) into a 10-bit offset-binary code for a digital-to-analog converter. A phase accumulator, stepped by a frequency tuning word, addresses an internal sine table. Cosine is read from the same table a quarter period ahead. Each cycle the block forms the in-phase value times cosine minus the quadrature value times sine, with full-precision signed multiplies. It divides the difference by 64 with truncation toward zero and adds a mid-scale offset of 512, which produces an unsigned code centred on the converter's midpoint.

A tone mode bypasses the mixing and emits the plain sine carrier, scaled by four and offset to mid-scale. This mode is useful for bringing up the converter path. Operands and table values are captured on the rising clock edge. The output code is registered on the following falling edge.

Top module: `iqmod_core`

## Requirements
- R1: While `rst` is high at a falling edge, `dac_code` is 512. The phase accumulator clears, so the first code after reset release is computed at table address 0.
- R2: A 16-bit phase accumulator adds `ftw` at every rising edge and wraps modulo 65536. The table address is the upper 8 bits of the accumulator, and cosine is read at that address plus 64, modulo 256.
- R3: The table has 256 signed 8-bit sine entries, each within -127..+127 (never -128). Addresses 0, 64, 128 and 192 hold 0, +127, 0 and -127.
- R4: In mixing mode (`tone_only` low), the code is trunc((I*cos - Q*sin)/64) + 512, where each product is an exact signed 8x8 multiply.
- R5: The division by 64 truncates toward zero, so a difference of -127 gives -1 and code 511, not 510. In mixing mode every code lies within 8..1016.
- R6: Each product is limited symmetrically to +/-16383 before the subtraction. The +/-127 table keeps legal operands inside that limit, so an operand of -128 mixes at full value: I=-128 at address 0 gives code 258.
- R7: With `tone_only` high, the code is sin*4 + 512 and I and Q have no effect. For `ftw`=0x4000, the codes step through 512, 1020, 512, 4.
- R8: I, Q, `tone_only` and the table read are captured at a rising edge. The code they produce appears at the next falling edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operands and phase on the rising edge, output on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| ftw | input | 16 | Frequency tuning word added to the phase each cycle |
| i_in | input | 8 | Signed in-phase value |
| q_in | input | 8 | Signed quadrature value |
| tone_only | input | 1 | 1 selects the sine-only carrier output |
| dac_code | output | 10 | Offset-binary converter code |

## Verification
A corrupted phase accumulator shows at the ports within one cycle: quadrature tuning words such as 0x4000, 0xC000 and 0x2000 make the codes land on the table axis points in a predictable order, and a wrong step or wrap breaks that sequence. A wrong table entry, or a sign error in a product, shows as a code offset from 512 by exactly I or Q times 127 over 64. A floor-style shift shows as an off-by-one code for small negative differences. A wrong edge or a missing operand register shows as the new code arriving half a cycle early, or one cycle late, after a step on I.

// File: rtl/iqm_pkg.sv
`timescale 1ns/1ps
package iqm_pkg;

    localparam int SAMP_W   = 8;
    localparam int DAC_W    = 10;
    localparam int PROD_W   = 2 * SAMP_W;
    localparam int MIX_W    = PROD_W + 1;
    localparam int SUM_W    = MIX_W + 1;
    localparam int SCALE_SH = 6;
    localparam int TONE_SH  = 2;
    localparam int AMP_MAX  = (1 << (SAMP_W - 1)) - 1;
    localparam int PROD_LIM = (1 << (PROD_W - 2)) - 1;
    localparam int DAC_MID  = 1 << (DAC_W - 1);
    localparam int DAC_TOP  = (1 << DAC_W) - 1;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [MIX_W-1:0]  mix_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic [DAC_W-1:0]         code_t;

    typedef enum logic {
        PATH_MIX  = 1'b0,
        PATH_TONE = 1'b1
    } path_e;

    typedef struct packed {
        samp_t i_v;
        samp_t q_v;
        samp_t sin_v;
        samp_t cos_v;
        path_e path;
    } mix_op_t;

    // Rational half-wave sine approximation, peak exactly AMP_MAX,
    // never reaching the negative extreme of the sample type.
    function automatic samp_t sine_entry(input int idx, input int aw);
        longint half;
        longint n;
        longint p;
        longint num;
        longint den;
        longint v;
        half = longint'(1) << (aw - 1);
        n    = longint'(idx) % half;
        p    = n * (half - n);
        den  = 5 * half * half - 4 * p;
        num  = 16 * longint'(AMP_MAX) * p;
        v    = (num + den / 2) / den;
        if (longint'(idx) >= half) v = -v;
        return samp_t'(v);
    endfunction

    function automatic prod_t sat_prod(input prod_t x);
        prod_t lim;
        lim = prod_t'(PROD_LIM);
        if (x > lim)  return lim;
        if (x < -lim) return -lim;
        return x;
    endfunction

endpackage

// File: rtl/iqm_phase_acc.sv
`timescale 1ns/1ps
module iqm_phase_acc #(
    parameter int PHASE_W = 16,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] ftw,
    output logic [PHASE_W-1:0] phase_o,
    output logic [ADDR_W-1:0]  addr_o
);

    logic [PHASE_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + ftw;
        end
    end

    assign phase_o = phase_q;
    assign addr_o  = phase_q[PHASE_W-1 -: ADDR_W];

endmodule

// File: rtl/iqm_sincos_rom.sv
`timescale 1ns/1ps
module iqm_sincos_rom
    import iqm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    output samp_t             sin_o,
    output samp_t             cos_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] QTR = ADDR_W'(DEPTH / 4);

    samp_t tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
        assign tbl[g] = sine_entry(g, ADDR_W);
    end

    logic [ADDR_W-1:0] cos_addr;
    assign cos_addr = addr_i + QTR;

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_o <= '0;
            cos_o <= '0;
        end else begin
            sin_o <= tbl[addr_i];
            cos_o <= tbl[cos_addr];
        end
    end

endmodule

// File: rtl/iqm_mixer.sv
`timescale 1ns/1ps
module iqm_mixer
    import iqm_pkg::*;
(
    input  mix_op_t op_i,
    output code_t   code_o
);

    prod_t p_i_raw;
    prod_t p_q_raw;
    prod_t p_i;
    prod_t p_q;
    mix_t  diff;
    mix_t  adj;
    mix_t  quo;
    mix_t  tone_v;
    sum_t  sel_v;
    sum_t  total;

    always_comb begin
        p_i_raw = prod_t'(op_i.i_v) * prod_t'(op_i.cos_v);
        p_q_raw = prod_t'(op_i.q_v) * prod_t'(op_i.sin_v);
        p_i     = sat_prod(p_i_raw);
        p_q     = sat_prod(p_q_raw);
        diff    = mix_t'(p_i) - mix_t'(p_q);
        // bias negative values so the shift rounds toward zero
        adj     = diff[MIX_W-1] ? diff + mix_t'((1 << SCALE_SH) - 1) : diff;
        quo     = adj >>> SCALE_SH;
        tone_v  = mix_t'(op_i.sin_v) <<< TONE_SH;
        case (op_i.path)
            PATH_TONE: sel_v = sum_t'(tone_v);
            default:   sel_v = sum_t'(quo);
        endcase
        total = sel_v + sum_t'(DAC_MID);
        if (total < 0) begin
            code_o = '0;
        end else if (total > sum_t'(DAC_TOP)) begin
            code_o = code_t'(DAC_TOP);
        end else begin
            code_o = total[DAC_W-1:0];
        end
    end

endmodule

// File: rtl/iqmod_core.sv
`timescale 1ns/1ps
module iqmod_core
    import iqm_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int ADDR_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [PHASE_W-1:0]       ftw,
    input  logic signed [SAMP_W-1:0] i_in,
    input  logic signed [SAMP_W-1:0] q_in,
    input  logic                     tone_only,
    output logic [DAC_W-1:0]         dac_code
);

    logic [PHASE_W-1:0] phase_w;
    logic [ADDR_W-1:0]  addr_w;
    samp_t              sin_w;
    samp_t              cos_w;
    samp_t              i_q;
    samp_t              q_q;
    path_e              path_q;
    mix_op_t            op_c;
    code_t              code_w;

    iqm_phase_acc #(
        .PHASE_W (PHASE_W),
        .ADDR_W  (ADDR_W)
    ) u_acc (
        .clk     (clk),
        .rst     (rst),
        .ftw     (ftw),
        .phase_o (phase_w),
        .addr_o  (addr_w)
    );

    iqm_sincos_rom #(
        .ADDR_W (ADDR_W)
    ) u_rom (
        .clk    (clk),
        .rst    (rst),
        .addr_i (addr_w),
        .sin_o  (sin_w),
        .cos_o  (cos_w)
    );

    // operands captured on the same edge as the table read
    always_ff @(posedge clk) begin
        if (rst) begin
            i_q    <= '0;
            q_q    <= '0;
            path_q <= PATH_MIX;
        end else begin
            i_q    <= i_in;
            q_q    <= q_in;
            path_q <= tone_only ? PATH_TONE : PATH_MIX;
        end
    end

    always_comb begin
        op_c.i_v   = i_q;
        op_c.q_v   = q_q;
        op_c.sin_v = sin_w;
        op_c.cos_v = cos_w;
        op_c.path  = path_q;
    end

    iqm_mixer u_mix (
        .op_i   (op_c),
        .code_o (code_w)
    );

    always_ff @(negedge clk) begin
        if (rst) begin
            dac_code <= code_t'(DAC_MID);
        end else begin
            dac_code <= code_w;
        end
    end

endmodule

// File: rtl/iqmod_core_chk.sv
`timescale 1ns/1ps
module iqmod_core_chk
    import iqm_pkg::*;
#(
    parameter int PHASE_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [PHASE_W-1:0] ftw,
    input logic [PHASE_W-1:0] phase,
    input samp_t              sin_v,
    input samp_t              cos_v,
    input samp_t              i_v,
    input samp_t              q_v,
    input logic               tone,
    input code_t              dac_code
);

    // R2: accumulator steps by the tuning word, modulo 2^PHASE_W
    a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (phase == PHASE_W'($past(phase) + $past(ftw))));

    // R3: table values never reach the negative extreme
    a_r3_table_span: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((sin_v >= -samp_t'(AMP_MAX)) && (cos_v >= -samp_t'(AMP_MAX))));

    // R3: where sine is zero, cosine sits at a full-scale axis point
    a_r3_axis_points: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (sin_v == 0)) |-> ((cos_v == samp_t'(AMP_MAX)) || (cos_v == -samp_t'(AMP_MAX))));

    // R4: zero operands in mixing mode give mid-scale
    a_r4_zero_operands: assert property (@(negedge clk) disable iff (rst)
        ((i_v == 0) && (q_v == 0) && !tone) |=> (dac_code == code_t'(DAC_MID)));

    // R5: mixing-mode codes stay inside 8..1016
    a_r5_mix_span: assert property (@(negedge clk) disable iff (rst)
        !tone |=> ((dac_code >= code_t'(8)) && (dac_code <= code_t'(1016))));

    // R7: tone codes sit on a grid of four inside 4..1020
    a_r7_tone_grid: assert property (@(negedge clk) disable iff (rst)
        tone |=> ((dac_code[1:0] == 2'b00) && (dac_code >= code_t'(4)) && (dac_code <= code_t'(1020))));

endmodule

bind iqmod_core iqmod_core_chk #(
    .PHASE_W (PHASE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ftw      (ftw),
    .phase    (phase_w),
    .sin_v    (sin_w),
    .cos_v    (cos_w),
    .i_v      (i_q),
    .q_v      (q_q),
    .tone     (path_q),
    .dac_code (dac_code)
);

// File: tb/iqmod_core_tb_top.sv
`timescale 1ns/1ps
module iqmod_core_tb_top;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [15:0]       ftw = '0;
    logic signed [7:0] i_in = '0;
    logic signed [7:0] q_in = '0;
    logic              tone_only = 1'b0;
    logic [9:0]        dac_code;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    iqmod_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .ftw       (ftw),
        .i_in      (i_in),
        .q_in      (q_in),
        .tone_only (tone_only),
        .dac_code  (dac_code)
    );

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // table axis values from R3
    function automatic int sin_at(input int a);
        case (a % 256)
            0:       return 0;
            64:      return 127;
            128:     return 0;
            192:     return -127;
            default: return 0;
        endcase
    endfunction

    function automatic int cos_at(input int a);
        return sin_at((a + 64) % 256);
    endfunction

    // R4 / R5 / R7 expected code (SV integer division truncates toward zero)
    function automatic int exp_code(input int i, input int q, input int a, input bit t);
        int s;
        int c;
        s = sin_at(a);
        c = cos_at(a);
        if (t) return s * 4 + 512;
        return (i * c - q * s) / 64 + 512;
    endfunction

    task automatic start(input logic [15:0] f, input int i, input int q, input bit t);
        @(negedge clk);
        #1;
        rst       = 1'b1;
        ftw       = f;
        i_in      = 8'(i);
        q_in      = 8'(q);
        tone_only = t;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        rst = 1'b0;
        @(posedge clk);
    endtask

    task automatic sample_at(input int a, input int i, input int q, input bit t, input string tag);
        @(posedge clk);
        #2;
        chk(int'(dac_code), exp_code(i, q, a, t), tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        rst  = 1'b1;
        i_in = 8'sd100;
        q_in = -8'sd50;
        ftw  = 16'h1234;
        repeat (3) @(posedge clk);
        #2;
        chk(int'(dac_code), 512, "R1 code during reset");
    endtask

    // 0x4000 visits addresses 0, 64, 128, 192 and wraps back to 0
    task automatic t_quadrature(input int i, input int q, input string tag);
        start(16'h4000, i, q, 1'b0);
        for (int k = 0; k < 5; k++) begin
            sample_at((k * 64) % 256, i, q, 1'b0, tag);
        end
    endtask

    task automatic t_reverse();
        start(16'hC000, 30, -70, 1'b0);
        for (int k = 0; k < 5; k++) begin
            sample_at((k * 192) % 256, 30, -70, 1'b0, "R2 backward wrap");
        end
    endtask

    task automatic t_eighth_step();
        start(16'h2000, -90, 45, 1'b0);
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            #2;
            if ((k % 2) == 0) begin
                chk(int'(dac_code), exp_code(-90, 45, k * 32, 1'b0), "R2 half-quadrant step");
            end
        end
    endtask

    task automatic t_first_after_reset();
        start(16'h4000, 64, 0, 1'b0);
        sample_at(0, 64, 0, 1'b0, "R1 first code at address 0");
    endtask

    task automatic t_tone();
        start(16'h4000, -128, -128, 1'b1);
        sample_at(0, -128, -128, 1'b1, "R7 tone addr0");
        sample_at(64, -128, -128, 1'b1, "R7 tone addr64");
        i_in = 8'sd127;
        q_in = 8'sd99;
        sample_at(128, 127, 99, 1'b1, "R7 tone addr128");
        sample_at(192, 127, 99, 1'b1, "R7 tone addr192 I/Q ignored");
        chk(int'(dac_code), 4, "R7 tone negative peak");
    endtask

    task automatic t_timing();
        start(16'h0000, 40, 0, 1'b0);
        sample_at(0, 40, 0, 1'b0, "R8 hold before step");
        i_in = -8'sd40;
        @(posedge clk);
        #2;
        chk(int'(dac_code), 591, "R8 no change before falling edge");
        @(negedge clk);
        #2;
        chk(int'(dac_code), 433, "R8 change after falling edge");
        tone_only = 1'b1;
        @(posedge clk);
        #2;
        chk(int'(dac_code), 433, "R8 mode change not before falling edge");
        @(negedge clk);
        #2;
        chk(int'(dac_code), 512, "R8 mode change after falling edge");
    endtask

    initial begin
        t_reset();
        t_first_after_reset();
        t_quadrature(100, -60, "R3 R4 axis points");
        t_quadrature(-1, 5, "R5 truncation toward zero");
        chk(exp_code(-1, 5, 0, 1'b0), 511, "R5 bench model");
        t_quadrature(1, -1, "R5 small positive");
        t_quadrature(-128, -128, "R6 extreme negative operands");
        t_quadrature(127, 127, "R6 extreme positive operands");
        t_reverse();
        t_eighth_step();
        t_tone();
        t_timing();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(50000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule